// File: doc/BRIEF.md
# Rectangle Fill and Copy Engine

This block is a small 2D drawing engine for a byte-addressed frame buffer. Software writes a set of configuration registers (source and destination corners, rectangle size, row pitches, a fill colour) and then writes a control word with the start bit set. The engine walks the rectangle row by row. It either writes one colour byte per location (solid fill) or reads each source byte and writes it to the matching destination location (screen copy). It reaches memory through a simple synchronous port that can stall on `mem_ready`.

The copy can run backwards. In that mode the programmed corners are the last column and last row of each rectangle, and both coordinates count down. When software picks the direction correctly (backward when the destination lies below the source, or on the same row to its right), an overlapping copy gives the same result as copying from an untouched snapshot of the source. Widths are counted in bytes, so the pixel count times the bytes per pixel is written into the width field. A busy flag is set while an operation runs and clears when its last write has been accepted. Software polls this flag.

Top module: `blit2d_engine`

## Requirements
- R1: Registers can be written and read back. Offset 0x00 is the source corner and 0x04 the destination corner, each with x in bits 31:16 and y in bits 15:0. Offset 0x08 holds the width in bytes in bits 31:16 and the height in bits 15:0. Offset 0x10 holds the source pitch in bits 15:0 and the destination pitch in bits 31:16. Offset 0x14 is the foreground colour. All registers reset to zero.
- R2: A write of the control word at offset 0x0C with bit 31 set starts an operation when the engine is idle. Bits 19:16 select the command: 0x0 is a copy and 0x1 is a fill. Any other command code starts nothing.
- R3: A fill writes byte 7:0 of the foreground colour once to every byte of the destination rectangle. Bytes are written along a row first and then row by row, at address y·dst_pitch + x, one write per accepted clock.
- R4: A copy performs, for each byte, a read at y·src_pitch + x followed directly by a write of that byte at the matching destination address.
- R5: With control bit 27 set, the programmed corners are the last byte column and last row, and the engine decrements x along a row and y between rows. With bit 27 clear, it increments both.
- R6: Software chooses the direction: backward when the destination starts below the source, or on the same row to its right. An overlapping copy then leaves the destination equal to the original source contents, and no byte outside the destination changes.
- R7: While `mem_req` is high and `mem_ready` is low, the request, address, write flag and write data hold their values until the transfer is accepted.
- R8: The `busy` output and bit 3 of the status register at offset 0x18 read 1 from the clock after the start until the clock on which the final write is accepted. After that they read 0.
- R9: Register writes made while busy, including a second start, have no effect.
- R10: A start with zero width or zero height makes no memory access and never raises busy.
- R11: Bits 30:0 of the control word, including the raster-operation code in bits 15:0 (0x0C for a plain copy), read back exactly as written. Bit 31 reads as the busy flag.
- R12: After reset the engine is idle, `mem_req` is low and every register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational from cfg_addr) |
| busy | output | 1 | Operation in progress |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid while a read is accepted |
| mem_ready | input | 1 | Transfer accepted on this clock |

## Verification
The bench targets overlapping copies in every arrangement: destination below and to the right, destination on the same row to the left, and destination above. An engine that walks in the wrong order, or that ignores the direction bit, reads bytes it has already overwritten, and the final frame buffer then shows smeared, repeated data. Stalls from `mem_ready` are inserted during copies. A design that advances on request instead of on acceptance skips bytes, and one that lets the address drift during a stall writes to the wrong location. Zero-size starts, unknown command codes and register writes during busy are also exercised. A design that got any of these wrong would issue stray memory transactions or change the programmed geometry, and the transaction-by-transaction comparison against the reference model catches both.

// File: rtl/blit_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the rectangle engine: register offsets, command
// codes, coordinate types and the walker state encoding.
package blit_pkg;
    localparam int COORD_W = 16;
    localparam int REG_AW  = 5;

    localparam logic [REG_AW-1:0] OFS_SRC   = 5'h00;
    localparam logic [REG_AW-1:0] OFS_DST   = 5'h04;
    localparam logic [REG_AW-1:0] OFS_DIM   = 5'h08;
    localparam logic [REG_AW-1:0] OFS_CTRL  = 5'h0C;
    localparam logic [REG_AW-1:0] OFS_PITCH = 5'h10;
    localparam logic [REG_AW-1:0] OFS_FG    = 5'h14;
    localparam logic [REG_AW-1:0] OFS_STAT  = 5'h18;

    localparam int CTRL_GO_BIT   = 31;
    localparam int CTRL_BACK_BIT = 27;
    localparam int STAT_BUSY_BIT = 3;

    typedef enum logic [3:0] {
        CMD_COPY = 4'h0,
        CMD_FILL = 4'h1
    } blit_cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_WR   = 2'd2
    } walk_st_e;

    typedef struct packed {
        logic [COORD_W-1:0] x;
        logic [COORD_W-1:0] y;
    } xy_t;
endpackage

// File: rtl/blit_addr.sv
`timescale 1ns/1ps
// Linear address generator: addr = y * pitch + x.
// Assumes AW is at most 2*COORD_W; upper product bits are dropped.
module blit_addr
    import blit_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [COORD_W-1:0] x_i,
    input  logic [COORD_W-1:0] y_i,
    input  logic [COORD_W-1:0] pitch_i,
    output logic [AW-1:0]      addr_o
);
    localparam int FULL_W = 2 * COORD_W;

    logic [FULL_W-1:0] lin;

    // Row offset plus column, computed at full width.
    always_comb begin
        lin = {{COORD_W{1'b0}}, y_i} * {{COORD_W{1'b0}}, pitch_i}
            + {{COORD_W{1'b0}}, x_i};
    end

    assign addr_o = lin[AW-1:0];
endmodule

// File: rtl/blit_regs.sv
`timescale 1ns/1ps
// Configuration register file. Holds geometry, pitches, colour and the
// control word, and decodes the start request. All writes are dropped
// while the walker reports busy. Assumes single-cycle register writes.
module blit_regs
    import blit_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [REG_AW-1:0]  cfg_addr,
    input  logic [31:0]        cfg_wdata,
    output logic [31:0]        cfg_rdata,
    input  logic               busy_i,
    output xy_t                src_o,
    output xy_t                dst_o,
    output logic [COORD_W-1:0] width_o,
    output logic [COORD_W-1:0] height_o,
    output logic [COORD_W-1:0] spitch_o,
    output logic [COORD_W-1:0] dpitch_o,
    output logic [7:0]         fg_o,
    output logic               go_o,
    output logic [3:0]         go_cmd_o,
    output logic               go_back_o
);
    xy_t         src_q, dst_q;
    logic [31:0] dim_q, pitch_q, fg_q;
    logic [30:0] ctrl_q;
    logic        wr_ok;

    assign wr_ok = cfg_we && !busy_i;

    // Register storage; writes accepted only while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q   <= '0;
            dst_q   <= '0;
            dim_q   <= '0;
            pitch_q <= '0;
            fg_q    <= '0;
            ctrl_q  <= '0;
        end else if (wr_ok) begin
            case (cfg_addr)
                OFS_SRC:   src_q   <= cfg_wdata;
                OFS_DST:   dst_q   <= cfg_wdata;
                OFS_DIM:   dim_q   <= cfg_wdata;
                OFS_PITCH: pitch_q <= cfg_wdata;
                OFS_FG:    fg_q    <= cfg_wdata;
                OFS_CTRL:  ctrl_q  <= cfg_wdata[30:0];
                default:   ;
            endcase
        end
    end

    // Read mux; the start bit position reports busy.
    always_comb begin
        case (cfg_addr)
            OFS_SRC:   cfg_rdata = src_q;
            OFS_DST:   cfg_rdata = dst_q;
            OFS_DIM:   cfg_rdata = dim_q;
            OFS_PITCH: cfg_rdata = pitch_q;
            OFS_FG:    cfg_rdata = fg_q;
            OFS_CTRL:  cfg_rdata = {busy_i, ctrl_q};
            OFS_STAT:  cfg_rdata = 32'(busy_i) << STAT_BUSY_BIT;
            default:   cfg_rdata = '0;
        endcase
    end

    assign src_o     = src_q;
    assign dst_o     = dst_q;
    assign width_o   = dim_q[31:16];
    assign height_o  = dim_q[15:0];
    assign spitch_o  = pitch_q[15:0];
    assign dpitch_o  = pitch_q[31:16];
    assign fg_o      = fg_q[7:0];
    assign go_o      = wr_ok && (cfg_addr == OFS_CTRL) && cfg_wdata[CTRL_GO_BIT];
    assign go_cmd_o  = cfg_wdata[19:16];
    assign go_back_o = cfg_wdata[CTRL_BACK_BIT];

    // R9
    busy_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && cfg_we) |=> ($stable(src_q) && $stable(dst_q) && $stable(dim_q)
                                && $stable(pitch_q) && $stable(ctrl_q) && $stable(fg_q)));
endmodule

// File: rtl/blit_walker.sv
`timescale 1ns/1ps
// Rectangle walker and memory sequencer. Steps x along a row then y, up or
// down, issuing one transfer per accepted clock: fill = write only, copy =
// read then write. Assumes geometry inputs stay constant while busy.
module blit_walker
    import blit_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               go_i,
    input  logic [3:0]         go_cmd_i,
    input  logic               go_back_i,
    input  xy_t                src_i,
    input  xy_t                dst_i,
    input  logic [COORD_W-1:0] width_i,
    input  logic [COORD_W-1:0] height_i,
    input  logic [COORD_W-1:0] spitch_i,
    input  logic [COORD_W-1:0] dpitch_i,
    input  logic [7:0]         fg_i,
    output logic               busy_o,
    output logic               mem_req,
    output logic               mem_we,
    output logic [AW-1:0]      mem_addr,
    output logic [7:0]         mem_wdata,
    input  logic [7:0]         mem_rdata,
    input  logic               mem_ready
);
    walk_st_e           st;
    logic               fill_q, back_q;
    logic [COORD_W-1:0] ccnt, rcnt, sx, sy, dx, dy, sx0, dx0;
    logic [7:0]         hold_q;
    logic [AW-1:0]      saddr, daddr;
    logic               cmd_ok, launch, xfer, row_end, last;

    function automatic logic [COORD_W-1:0] nxt(input logic [COORD_W-1:0] v, input logic b);
        return b ? v - 1'b1 : v + 1'b1;
    endfunction

    blit_addr #(.AW(AW)) u_src_addr (.x_i(sx), .y_i(sy), .pitch_i(spitch_i), .addr_o(saddr));
    blit_addr #(.AW(AW)) u_dst_addr (.x_i(dx), .y_i(dy), .pitch_i(dpitch_i), .addr_o(daddr));

    assign cmd_ok  = (go_cmd_i == CMD_FILL) || (go_cmd_i == CMD_COPY);
    assign launch  = go_i && cmd_ok && (width_i != '0) && (height_i != '0) && (st == ST_IDLE);
    assign xfer    = mem_req && mem_ready;
    assign row_end = (ccnt == width_i - 1'b1);
    assign last    = row_end && (rcnt == height_i - 1'b1);

    // Sequencer: launch, read/write alternation and coordinate stepping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE;
            fill_q <= 1'b0;
            back_q <= 1'b0;
            ccnt <= '0; rcnt <= '0;
            sx <= '0; sy <= '0; dx <= '0; dy <= '0; sx0 <= '0; dx0 <= '0;
            hold_q <= '0;
        end else begin
            case (st)
                ST_IDLE: if (launch) begin
                    fill_q <= (go_cmd_i == CMD_FILL);
                    back_q <= go_back_i;
                    sx <= src_i.x; sx0 <= src_i.x; sy <= src_i.y;
                    dx <= dst_i.x; dx0 <= dst_i.x; dy <= dst_i.y;
                    ccnt <= '0; rcnt <= '0;
                    st <= (go_cmd_i == CMD_FILL) ? ST_WR : ST_RD;
                end
                ST_RD: if (xfer) begin
                    hold_q <= mem_rdata;
                    st <= ST_WR;
                end
                ST_WR: if (xfer) begin
                    if (last) begin
                        st <= ST_IDLE;
                    end else begin
                        st <= fill_q ? ST_WR : ST_RD;
                        if (row_end) begin
                            ccnt <= '0;
                            rcnt <= rcnt + 1'b1;
                            sx <= sx0;
                            dx <= dx0;
                            sy <= nxt(sy, back_q);
                            dy <= nxt(dy, back_q);
                        end else begin
                            ccnt <= ccnt + 1'b1;
                            sx <= nxt(sx, back_q);
                            dx <= nxt(dx, back_q);
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Memory port drive from state.
    always_comb begin
        mem_req   = (st != ST_IDLE);
        mem_we    = (st == ST_WR);
        mem_addr  = (st == ST_RD) ? saddr : daddr;
        mem_wdata = fill_q ? fg_i : hold_q;
    end

    assign busy_o = (st != ST_IDLE);

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));
    // R4
    rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ready && !mem_we) |=> (mem_req && mem_we));
    // R8
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> $past(mem_req && mem_ready && mem_we));
    // R3
    fill_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_q && mem_req && mem_we) |-> (mem_wdata == fg_i));
endmodule

// File: rtl/blit2d_engine.sv
`timescale 1ns/1ps
// Top of the rectangle fill/copy engine: register file plus walker.
// Assumes a byte-wide memory port whose read data is valid on the
// accepting clock.
module blit2d_engine
    import blit_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [4:0]        cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    output logic              busy,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    input  logic              mem_ready
);
    xy_t                src, dst;
    logic [COORD_W-1:0] width, height, spitch, dpitch;
    logic [7:0]         fg;
    logic               go, go_back;
    logic [3:0]         go_cmd;

    blit_regs u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .busy_i(busy),
        .src_o(src), .dst_o(dst), .width_o(width), .height_o(height),
        .spitch_o(spitch), .dpitch_o(dpitch), .fg_o(fg),
        .go_o(go), .go_cmd_o(go_cmd), .go_back_o(go_back)
    );

    blit_walker #(.AW(ADDR_W)) u_walk (
        .clk(clk), .rst_n(rst_n), .go_i(go), .go_cmd_i(go_cmd), .go_back_i(go_back),
        .src_i(src), .dst_i(dst), .width_i(width), .height_i(height),
        .spitch_i(spitch), .dpitch_i(dpitch), .fg_i(fg), .busy_o(busy),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready)
    );
endmodule

// File: tb/tb_blit2d_engine.sv
`timescale 1ns/1ps
module tb_blit2d_engine;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        cfg_we = 0;
    logic [4:0]  cfg_addr = 0;
    logic [31:0] cfg_wdata = 0;
    logic [31:0] cfg_rdata;
    logic        busy, mem_req, mem_we, mem_ready;
    logic [31:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;

    always #2.5 clk = ~clk;

    blit2d_engine dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .busy(busy),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready)
    );

    // Frame buffer model and reference arrays.
    logic [7:0] mem    [0:4095];
    logic [7:0] shadow [0:4095];
    logic [7:0] expm   [0:4095];
    logic [7:0] snap   [0:4095];

    int  cyc = 0;
    bit  stall_mode = 0;
    bit  mon_on = 0;
    bit  finished = 0;
    int  nchk = 0, nerr = 0;

    assign mem_ready = stall_mode ? (cyc % 3 != 1) : 1'b1;
    assign mem_rdata = mem[mem_addr[11:0]];

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_req && mem_ready && mem_we) mem[mem_addr[11:0]] <= mem_wdata;
    end

    typedef struct { bit we; int addr; int data; string tag; } txn_t;
    txn_t q[$];

    task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Per-clock comparison with the reference model.
    bit       prev_stall = 0;
    int       prev_addr = 0;
    bit       prev_we = 0;
    int       prev_wd = 0;
    always @(negedge clk) begin
        if (rst_n && mon_on) begin
            chk(busy == (q.size() != 0), "R8", "busy vs model", busy, q.size() != 0);
            if (prev_stall)
                chk(mem_req && mem_addr == prev_addr && mem_we == prev_we && mem_wdata == prev_wd,
                    "R7", "stall hold addr", mem_addr, prev_addr);
            if (mem_req && mem_ready) begin
                if (q.size() == 0) begin
                    chk(0, "R10", "unexpected transfer addr", mem_addr, 0);
                end else begin
                    chk(mem_we == q[0].we && mem_addr == q[0].addr, q[0].tag, "transfer addr",
                        {mem_we, mem_addr}, {q[0].we, q[0].addr[31:0]});
                    if (q[0].we)
                        chk(mem_wdata == q[0].data, q[0].tag, "write data", mem_wdata, q[0].data);
                    void'(q.pop_front());
                end
            end
            prev_stall = mem_req && !mem_ready;
            prev_addr = mem_addr;
            prev_we = mem_we;
            prev_wd = mem_wdata;
        end
    end

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1; cfg_addr = a; cfg_wdata = d;
        @(posedge clk);
        #1 cfg_we = 0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    // Builds expected transfer list and final memory for one command.
    task automatic plan(input int cmd, input bit back, input int sx, input int sy, input int dx,
                        input int dy, input int w, input int h, input int sp, input int dp,
                        input int fgv, input string tag);
        for (int i = 0; i < 4096; i++) begin shadow[i] = mem[i]; snap[i] = mem[i]; expm[i] = mem[i]; end
        if (cmd != 0 && cmd != 1) return;
        for (int r = 0; r < h; r++)
            for (int c = 0; c < w; c++) begin
                int xs, ys, xd, yd, v;
                xs = back ? sx - c : sx + c;  ys = back ? sy - r : sy + r;
                xd = back ? dx - c : dx + c;  yd = back ? dy - r : dy + r;
                if (cmd == 1) begin
                    q.push_back('{1'b1, yd * dp + xd, fgv & 255, tag});
                end else begin
                    v = shadow[ys * sp + xs];
                    q.push_back('{1'b0, ys * sp + xs, 0, tag});
                    q.push_back('{1'b1, yd * dp + xd, v, tag});
                    shadow[yd * dp + xd] = v[7:0];
                end
            end
        // Independent final image from the untouched snapshot.
        for (int r = 0; r < h; r++)
            for (int c = 0; c < w; c++) begin
                int ox_s, oy_s, ox_d, oy_d;
                ox_s = back ? sx - w + 1 : sx;  oy_s = back ? sy - h + 1 : sy;
                ox_d = back ? dx - w + 1 : dx;  oy_d = back ? dy - h + 1 : dy;
                expm[(oy_d + r) * dp + ox_d + c] = (cmd == 1) ? fgv[7:0] : snap[(oy_s + r) * sp + ox_s + c];
            end
    endtask

    int cur_ctrl;

    task automatic launch(input int cmd, input bit back, input int sx, input int sy, input int dx,
                          input int dy, input int w, input int h, input int sp, input int dp,
                          input int fgv, input string tag);
        wr(5'h00, {sx[15:0], sy[15:0]});
        wr(5'h04, {dx[15:0], dy[15:0]});
        wr(5'h08, {w[15:0], h[15:0]});
        wr(5'h10, {dp[15:0], sp[15:0]});
        wr(5'h14, fgv);
        cur_ctrl = 32'h8000_0000 | (int'(back) << 27) | ((cmd & 15) << 16) | 32'h0000_000C;
        @(negedge clk);
        cfg_we = 1; cfg_addr = 5'h0C; cfg_wdata = cur_ctrl;
        @(posedge clk);
        #1 cfg_we = 0;
        plan(cmd, back, sx, sy, dx, dy, w, h, sp, dp, fgv, tag);
    endtask

    task automatic finish_op(input string req);
        logic [31:0] d;
        int mis;
        @(negedge clk);
        while (busy) @(negedge clk);
        @(negedge clk);
        chk(q.size() == 0, req, "pending transfers", q.size(), 0);
        mis = 0;
        for (int i = 0; i < 4096; i++) if (mem[i] !== expm[i]) mis++;
        chk(mis == 0, req, "final image mismatches", mis, 0);
        rd(5'h0C, d);
        chk(d == {1'b0, cur_ctrl[30:0]}, "R11", "ctrl readback", d, {1'b0, cur_ctrl[30:0]});
    endtask

    initial begin
        logic [31:0] d;
        for (int i = 0; i < 4096; i++) mem[i] = 8'((i * 7 + 3) ^ (i >> 5));
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R12 reset state
        @(negedge clk);
        chk(!busy && !mem_req, "R12", "idle after reset", {busy, mem_req}, 0);
        for (int a = 0; a <= 24; a += 4) begin
            rd(a[4:0], d);
            chk(d == 0, "R12", "register reset value", d, 0);
        end
        mon_on = 1;
        // R1 register access
        wr(5'h00, 32'h0012_0034); rd(5'h00, d); chk(d == 32'h0012_0034, "R1", "src reg", d, 32'h0012_0034);
        wr(5'h08, 32'h0056_0078); rd(5'h08, d); chk(d == 32'h0056_0078, "R1", "dim reg", d, 32'h0056_0078);
        wr(5'h10, 32'h0020_0040); rd(5'h10, d); chk(d == 32'h0020_0040, "R1", "pitch reg", d, 32'h0020_0040);
        wr(5'h14, 32'hDEAD_BEA5); rd(5'h14, d); chk(d == 32'hDEAD_BEA5, "R1", "fg reg", d, 32'hDEAD_BEA5);
        // R3 forward fill
        launch(1, 0, 0, 0, 4, 2, 5, 3, 64, 64, 32'h1234_56A5, "R3");
        finish_op("R3");
        // R4 forward copy, different pitches, stalls (R7)
        stall_mode = 1;
        launch(0, 0, 0, 0, 1, 100, 7, 5, 64, 32, 0, "R4");
        finish_op("R4");
        // R5 R6 overlap, destination below-right, backward
        launch(0, 1, 17, 15, 20, 17, 8, 6, 64, 64, 0, "R5");
        finish_op("R6");
        // R6 overlap, same row, destination left, forward
        launch(0, 0, 20, 30, 17, 30, 10, 3, 64, 64, 0, "R6");
        finish_op("R6");
        // R6 overlap, destination above, forward
        launch(0, 0, 5, 40, 7, 38, 6, 4, 64, 64, 0, "R6");
        finish_op("R6");
        stall_mode = 0;
        // R5 backward fill
        launch(1, 1, 0, 0, 40, 50, 4, 3, 64, 64, 32'h0000_003C, "R5");
        finish_op("R5");
        // R10 zero width and zero height
        launch(1, 0, 0, 0, 2, 2, 0, 5, 64, 64, 32'h77, "R10");
        @(negedge clk);
        chk(!busy && !mem_req, "R10", "zero width stays idle", {busy, mem_req}, 0);
        finish_op("R10");
        launch(0, 0, 0, 0, 2, 2, 3, 0, 64, 64, 0, "R10");
        @(negedge clk);
        chk(!busy && !mem_req, "R10", "zero height stays idle", {busy, mem_req}, 0);
        finish_op("R10");
        // R2 unknown command code
        launch(2, 0, 0, 0, 2, 2, 3, 3, 64, 64, 0, "R2");
        @(negedge clk);
        chk(!busy && !mem_req, "R2", "unknown command idle", {busy, mem_req}, 0);
        finish_op("R2");
        // R9 writes during busy ignored; R8 status bit
        launch(1, 0, 0, 0, 0, 60, 20, 4, 64, 64, 32'h5A, "R9");
        rd(5'h18, d);
        chk(d == 32'h8, "R8", "status busy bit", d, 32'h8);
        wr(5'h08, 32'h0001_0001);
        wr(5'h04, 32'h0003_0003);
        wr(5'h0C, 32'h8000_000C);
        finish_op("R9");
        rd(5'h08, d); chk(d == 32'h0014_0004, "R9", "dim kept", d, 32'h0014_0004);
        rd(5'h04, d); chk(d == 32'h0000_003C, "R9", "dst kept", d, 32'h0000_003C);
        rd(5'h18, d); chk(d == 0, "R8", "status idle", d, 0);
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            nerr++; nchk++;
            $display("FAIL R8 watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end
endmodule